// File: doc/BRIEF.md
# Weaver-Method Single-Sideband Modulator

This block turns a stream of real, signed audio samples into a real single-sideband signal using the third (Weaver) method. Each accepted sample is multiplied by a fixed quadrature tone at the middle of the voice band (1650 Hz at the default 8 kHz sample rate). This places the wanted sideband around zero frequency. Two low-pass filters with identical coefficients, one on the in-phase path and one on the quadrature path, remove the image. A second quadrature oscillator then moves both paths up. The two products are either added (upper sideband) or subtracted (lower sideband). The phase offsets at both mixing stages are fixed 90-degree offsets. No band-pass filter and no wideband phase shifter appear anywhere in the signal path.

The caller gives a carrier phase increment that describes the suppressed-carrier frequency. The block folds the first oscillator's offset into that increment, adding it or taking it away according to the sideband. This means a tone at audio frequency fa always comes out at carrier+fa (upper) or carrier−fa (lower). Each accepted sample gives exactly one output sample after a fixed pipeline delay. Rate conversion and the DAC belong to the surrounding design.

Top module: `ssb_weaver_mod`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid` is 0 and `out_sample` is 0.
- R2: A sample accepted at a rising edge (`in_valid` high) appears on `out_sample` with `out_valid` high for exactly one cycle, after the third rising edge counted from and including the accepting edge. There is exactly one output per accepted sample.
- R3: With `sb_lower` = 0 (upper sideband), an audio tone at fa in the 1000–3000 Hz range produces an output tone at carrier+fa. The tone at carrier−fa is at least a factor of 6 smaller in amplitude.
- R4: With `sb_lower` = 1 (lower sideband), the output tone lies at carrier−fa. The tone at carrier+fa is at least a factor of 6 smaller.
- R5: `sb_lower` and `carrier_inc` are taken only in an idle cycle: a cycle with `in_valid` low and no sample inside the pipeline. Changes made while samples are in flight have no effect on the running stream.
- R6: An all-zero audio stream gives exactly zero on every output sample. There is no DC offset or rounding bias.
- R7: Both oscillators advance once per accepted sample and never on idle cycles. After reset, the output sequence depends only on the input samples and the configuration, not on how many idle cycles separate the samples.
- R8: The second oscillator increment (carrier ± first-oscillator increment) and both phase accumulators wrap modulo 2^32. A lower-sideband carrier below 1650 Hz therefore still gives the correct tone at |carrier−fa|.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Audio sample strobe, one sample per high cycle |
| in_audio | input | 16 | Signed audio sample |
| sb_lower | input | 1 | Sideband select: 0 upper (sum), 1 lower (difference) |
| carrier_inc | input | 32 | Carrier phase increment, carrier/fs × 2^32 |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed single-sideband output sample |

## Verification
The bench measures output tone amplitudes by correlation at carrier+fa and carrier−fa for both sidebands and for several carriers and tones. A swapped add/subtract or a missing offset fold would put the energy at the wrong frequency, and a weak filter would fail the factor-of-6 margin. One case places the lower-sideband carrier below the first oscillator frequency so the second increment goes negative. Broken modulo arithmetic would move that tone. The bench also flips the sideband and carrier in the middle of a back-to-back stream: a design that latched them while busy would jump to the new sideband. Two runs with different idle gaps must give identical samples, which would expose an oscillator that counts clocks instead of samples. A silent input checks that rounding adds no offset.

// File: rtl/ssbw_pkg.sv
package ssbw_pkg;

   typedef enum logic {
      SB_UPPER = 1'b0,
      SB_LOWER = 1'b1
   } sideband_e;

   // Rational sine approximation (integer only), one full period of 2^aw points,
   // scaled to the largest positive value of a dw-bit signed word.
   function automatic longint sine_point(input longint k, input int aw, input int dw);
      longint n, h, t, amp, num, den, v;
      bit     neg;
      n   = longint'(1) << aw;
      h   = n / 2;
      amp = (longint'(1) << (dw - 1)) - 1;
      if (k < h) begin
         t   = k;
         neg = 1'b0;
      end else begin
         t   = k - h;
         neg = 1'b1;
      end
      num = 16 * t * (h - t) * amp;
      den = 5 * h * h - 4 * t * (h - t);
      v   = (num + den / 2) / den;
      return neg ? -v : v;
   endfunction

   // Round half up after an arithmetic right shift, then clamp to dw signed bits.
   function automatic longint round_sat(input longint x, input int sh, input int dw);
      longint r, hi, lo;
      if (sh > 0) r = (x + (longint'(1) <<< (sh - 1))) >>> sh;
      else        r = x;
      hi = (longint'(1) << (dw - 1)) - 1;
      lo = -(longint'(1) << (dw - 1));
      if (r > hi)      r = hi;
      else if (r < lo) r = lo;
      return r;
   endfunction

endpackage

// File: rtl/ssbw_nco.sv
module ssbw_nco #(
   parameter int PW = 32,
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 step,
   input  logic [PW-1:0]        inc,
   output logic signed [DW-1:0] cos_o,
   output logic signed [DW-1:0] sin_o
);
   localparam int NPTS = 1 << AW;
   localparam int QTR  = NPTS / 4;

   if (AW < 4 || AW > 12) begin : g_bad_aw
      $error("ssbw_nco: AW must lie in 4..12");
   end
   if (AW > PW) begin : g_bad_pw
      $error("ssbw_nco: AW must not exceed PW");
   end
   if (DW < 8 || DW > 24) begin : g_bad_dw
      $error("ssbw_nco: DW must lie in 8..24");
   end

   logic signed [DW-1:0] wave [NPTS];

   for (genvar i = 0; i < NPTS; i++) begin : g_wave
      localparam longint PT = ssbw_pkg::sine_point(longint'(i), AW, DW);
      assign wave[i] = DW'(PT);
   end

   logic [PW-1:0] phase;
   logic [AW-1:0] s_idx, c_idx;

   always_ff @(posedge clk) begin
      if (rst)       phase <= '0;
      else if (step) phase <= phase + inc;
   end

   assign s_idx = phase[PW-1 -: AW];
   assign c_idx = s_idx + AW'(QTR);
   assign sin_o = wave[s_idx];
   assign cos_o = wave[c_idx];

   // R7: phase moves by exactly one increment per step, modulo 2^PW (R8)
   assert_phase_step_R7: assert property (@(posedge clk) disable iff (rst)
      step |=> (phase == $past(phase) + $past(inc)))
      else $error("phase did not advance by inc");

   // R7: no movement without a step
   assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(phase))
      else $error("phase moved on an idle cycle");

endmodule

// File: rtl/ssbw_mix1.sv
module ssbw_mix1 #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] audio,
   input  logic signed [DW-1:0] lo_cos,
   input  logic signed [DW-1:0] lo_sin,
   output logic                 v_o,
   output logic signed [DW-1:0] i_o,
   output logic signed [DW-1:0] q_o
);
   localparam int SH = DW - 1;

   logic signed [DW-1:0] i_n, q_n;

   always_comb begin
      i_n = DW'(ssbw_pkg::round_sat(longint'(audio) * longint'(lo_cos), SH, DW));
      q_n = DW'(ssbw_pkg::round_sat(longint'(audio) * longint'(lo_sin), SH, DW));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_o <= 1'b0;
         i_o <= '0;
         q_o <= '0;
      end else begin
         v_o <= in_valid;
         if (in_valid) begin
            i_o <= i_n;
            q_o <= q_n;
         end
      end
   end

   // R6: silence in gives silence out of the first mixer
   assert_zero_in_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && audio == '0) |=> (i_o == '0 && q_o == '0))
      else $error("first mixer produced output from zero input");

endmodule

// File: rtl/ssbw_fir.sv
module ssbw_fir #(
   parameter int DW     = 16,
   parameter int NTAPS  = 9,
   parameter int CW     = 16,
   parameter int CSHIFT = 15,
   parameter int COEF [NTAPS] = '{default: 0}
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 shift,
   input  logic signed [DW-1:0] din,
   output logic                 v_o,
   output logic signed [DW-1:0] dout
);
   localparam int HALF = NTAPS / 2;
   localparam int ACCW = DW + 1 + CW + $clog2(HALF + 1);
   localparam int CMAX = (1 << (CW - 1)) - 1;
   localparam int CMIN = -(1 << (CW - 1));

   if (NTAPS % 2 == 0 || NTAPS < 3) begin : g_bad_taps
      $error("ssbw_fir: NTAPS must be odd and at least 3");
   end
   if (ACCW > 63) begin : g_bad_accw
      $error("ssbw_fir: accumulator too wide");
   end
   for (genvar k = 0; k < NTAPS; k++) begin : g_coef_chk
      if (COEF[k] > CMAX || COEF[k] < CMIN) begin : g_range
         $error("ssbw_fir: coefficient outside CW bits");
      end
      if (COEF[k] != COEF[NTAPS-1-k]) begin : g_sym
         $error("ssbw_fir: coefficients must be symmetric");
      end
   end

   logic signed [DW-1:0] line [NTAPS-1];
   logic signed [DW-1:0] tap  [NTAPS];
   logic signed [DW:0]   pair [HALF];
   longint               acc;

   assign tap[0] = din;
   for (genvar k = 1; k < NTAPS; k++) begin : g_tap
      assign tap[k] = line[k-1];
   end

   for (genvar k = 0; k < HALF; k++) begin : g_pair
      assign pair[k] = (DW+1)'(tap[k]) + (DW+1)'(tap[NTAPS-1-k]);
   end

   always_comb begin
      acc = longint'(COEF[HALF]) * longint'(tap[HALF]);
      for (int k = 0; k < HALF; k++) begin
         acc = acc + longint'(COEF[k]) * longint'(pair[k]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_o  <= 1'b0;
         dout <= '0;
         for (int k = 0; k < NTAPS - 1; k++) line[k] <= '0;
      end else begin
         v_o <= shift;
         if (shift) begin
            line[0] <= din;
            for (int k = 1; k < NTAPS - 1; k++) line[k] <= line[k-1];
            dout <= DW'(ssbw_pkg::round_sat(acc, CSHIFT, DW));
         end
      end
   end

   // R7: history only advances when a sample arrives
   assert_line_load_R7: assert property (@(posedge clk) disable iff (rst)
      shift |=> (line[0] == $past(din)))
      else $error("filter history did not take the new sample");

   assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !shift |=> $stable(dout))
      else $error("filter output changed without a sample");

endmodule

// File: rtl/ssbw_combine.sv
module ssbw_combine #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 v_i,
   input  logic signed [DW-1:0] i_i,
   input  logic signed [DW-1:0] q_i,
   input  ssbw_pkg::sideband_e  side,
   input  logic signed [DW-1:0] lo_cos,
   input  logic signed [DW-1:0] lo_sin,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_sample
);
   localparam int SH = DW - 1;

   longint               p_i, p_q, mix;
   logic signed [DW-1:0] res;

   always_comb begin
      p_i = longint'(i_i) * longint'(lo_cos);
      p_q = longint'(q_i) * longint'(lo_sin);
      mix = (side == ssbw_pkg::SB_LOWER) ? (p_i - p_q) : (p_i + p_q);
      res = DW'(ssbw_pkg::round_sat(mix, SH, DW));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= v_i;
         if (v_i) out_sample <= res;
      end
   end

   // R6: zero baseband gives an exact zero
   assert_zero_out_R6: assert property (@(posedge clk) disable iff (rst)
      (v_i && i_i == '0 && q_i == '0) |=> (out_sample == '0))
      else $error("non-zero output from zero baseband");

   // R2: output word only changes with a strobe
   assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !v_i |=> $stable(out_sample))
      else $error("output changed without a strobe");

endmodule

// File: rtl/ssb_weaver_mod.sv
module ssb_weaver_mod #(
   parameter int DW       = 16,
   parameter int PW       = 32,
   parameter int LUT_AW   = 10,
   parameter int NTAPS    = 9,
   parameter int CW       = 16,
   parameter int CSHIFT   = 15,
   parameter int COEF [NTAPS] = '{-196, -31, 2524, 8275, 11624, 8275, 2524, -31, -196},
   parameter int FS_HZ    = 8000,
   parameter int LO1_HZ   = 1650
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_audio,
   input  logic                 sb_lower,
   input  logic [PW-1:0]        carrier_inc,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_sample
);
   localparam longint LO1_WIDE = (longint'(LO1_HZ) * (longint'(1) << PW) + longint'(FS_HZ / 2))
                                 / longint'(FS_HZ);
   localparam logic [PW-1:0] LO1_INC = PW'(LO1_WIDE);

   if (PW < 16 || PW > 40) begin : g_bad_pw
      $error("ssb_weaver_mod: PW must lie in 16..40");
   end
   if (2 * LO1_HZ >= FS_HZ || LO1_HZ <= 0) begin : g_bad_lo1
      $error("ssb_weaver_mod: first oscillator must sit below half the sample rate");
   end

   // ---------------- configuration, taken only when idle ----------------
   logic                va, vb;
   logic                idle;
   ssbw_pkg::sideband_e side_q;
   logic [PW-1:0]       inc2_q;

   assign idle = !in_valid && !va && !vb;

   always_ff @(posedge clk) begin
      if (rst) begin
         side_q <= ssbw_pkg::SB_UPPER;
         inc2_q <= '0;
      end else if (idle) begin
         side_q <= ssbw_pkg::sideband_e'(sb_lower);
         inc2_q <= sb_lower ? (carrier_inc - LO1_INC) : (carrier_inc + LO1_INC);
      end
   end

   // ---------------- stage A: shift wanted sideband to DC ----------------
   logic signed [DW-1:0] c1, s1, c2, s2;
   logic signed [DW-1:0] bb_raw [2];
   logic signed [DW-1:0] bb_flt [2];
   logic                 vflt [2];

   ssbw_nco #(.PW(PW), .AW(LUT_AW), .DW(DW)) u_lo1 (
      .clk(clk), .rst(rst), .step(in_valid), .inc(LO1_INC),
      .cos_o(c1), .sin_o(s1)
   );

   ssbw_mix1 #(.DW(DW)) u_mix1 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .audio(in_audio),
      .lo_cos(c1), .lo_sin(s1),
      .v_o(va), .i_o(bb_raw[0]), .q_o(bb_raw[1])
   );

   // ---------------- stage B: matched image-reject low-pass pair ----------
   for (genvar p = 0; p < 2; p++) begin : g_path
      ssbw_fir #(.DW(DW), .NTAPS(NTAPS), .CW(CW), .CSHIFT(CSHIFT), .COEF(COEF)) u_lpf (
         .clk(clk), .rst(rst), .shift(va), .din(bb_raw[p]),
         .v_o(vflt[p]), .dout(bb_flt[p])
      );
   end

   assign vb = vflt[0];

   // ---------------- stage C: up-convert and select sideband --------------
   ssbw_nco #(.PW(PW), .AW(LUT_AW), .DW(DW)) u_lo2 (
      .clk(clk), .rst(rst), .step(vb), .inc(inc2_q),
      .cos_o(c2), .sin_o(s2)
   );

   ssbw_combine #(.DW(DW)) u_comb (
      .clk(clk), .rst(rst), .v_i(vb), .i_i(bb_flt[0]), .q_i(bb_flt[1]),
      .side(side_q), .lo_cos(c2), .lo_sin(s2),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   // R2: fixed latency, one output per accepted sample
   assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##3 out_valid)
      else $error("output strobe missing three edges after input");

   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 3))
      else $error("output strobe without matching input");

   // R2: both filter paths stay in lockstep
   assert_paths_aligned_R2: assert property (@(posedge clk) disable iff (rst)
      vflt[0] == vflt[1])
      else $error("I and Q paths out of step");

   // R5: configuration frozen while a sample is in flight
   assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !idle |=> ($stable(side_q) && $stable(inc2_q)))
      else $error("configuration changed while busy");

   // R1: nothing leaves the block in the first cycle out of reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      $fell(rst) |-> (!out_valid && out_sample == '0))
      else $error("output active straight after reset");

endmodule

// File: tb/sim_ssb_weaver_mod.sv
module sim_ssb_weaver_mod;
   localparam real FS   = 8000.0;
   localparam int  NCAP = 1024;
   localparam int  SKIP = 16;
   localparam int  NCOR = 800;
   localparam real AMPL = 16000.0;

   // {sb_lower, carrier_hz, tone_hz, gap_cycles, requirement}
   localparam int NVEC = 6;
   localparam int VEC [NVEC][5] = '{
      '{0, 2000, 1000, 5, 3},   // R3 upper
      '{1, 2000, 1000, 5, 4},   // R4 lower
      '{0, 1500, 1500, 6, 3},   // R3 upper, tone at band centre
      '{1, 3000, 2500, 5, 4},   // R4 lower
      '{1,  500, 1000, 5, 8},   // R8 negative second increment wraps
      '{0,  500, 2900, 7, 3}    // R3 upper, near top of band
   };

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_audio = '0;
   logic               sb_lower = 1'b0;
   logic [31:0]        carrier_inc = '0;
   logic               out_valid;
   logic signed [15:0] out_sample;

   int checks = 0;
   int fails  = 0;
   int cap [NCAP];
   int cap_n = 0;
   int ref_seq [64];

   ssb_weaver_mod u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_audio(in_audio),
      .sb_lower(sb_lower), .carrier_inc(carrier_inc),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (out_valid && cap_n < NCAP) begin
         cap[cap_n] = int'(out_sample);
         cap_n++;
      end
   end

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still going, expected end before 150000 cycles");
      report();
      $finish;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input real act, input real exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] inc_of(input int hz);
      longint l;
      l = longint'(real'(hz) * 4294967296.0 / FS);
      return l[31:0];
   endfunction

   function automatic real tone_amp(input real hz, input int start, input int n);
      real c, s, ph;
      c = 0.0;
      s = 0.0;
      for (int k = 0; k < n; k++) begin
         ph = 2.0 * 3.14159265358979 * hz * real'(k) / FS;
         c += real'(cap[start + k]) * $cos(ph);
         s += real'(cap[start + k]) * $sin(ph);
      end
      return 2.0 * $sqrt(c * c + s * s) / real'(n);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      cap_n = 0;
   endtask

   task automatic send(input int s, input int gap);
      in_valid = 1'b1;
      in_audio = 16'(s);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap - 1) @(negedge clk);
   endtask

   function automatic int tone_sample(input int hz, input int n);
      return int'(AMPL * $sin(2.0 * 3.14159265358979 * real'(hz) * real'(n) / FS));
   endfunction

   task automatic configure(input bit lower, input int carrier_hz);
      sb_lower = lower;
      carrier_inc = inc_of(carrier_hz);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      real want, other, other2;
      int  wf, uf, nz, mism;
      string rq;

      // ---------------- R1: reset state ----------------
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid in reset", real'(out_valid), 0.0);
      check(out_sample == 16'sd0, "R1", "out_sample in reset", real'(out_sample), 0.0);
      rst = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0 && out_sample == 16'sd0, "R1", "outputs after release",
            real'(out_sample), 0.0);

      // ---------------- R2: latency of a single sample ----------------
      configure(1'b0, 2000);
      in_valid = 1'b1;
      in_audio = 16'sd1000;
      @(negedge clk);                   // accepting edge passed
      in_valid = 1'b0;
      check(out_valid == 1'b0, "R2", "strobe after 1 edge", real'(out_valid), 0.0);
      @(negedge clk);
      check(out_valid == 1'b0, "R2", "strobe after 2 edges", real'(out_valid), 0.0);
      @(negedge clk);
      check(out_valid == 1'b1, "R2", "strobe after 3 edges", real'(out_valid), 1.0);
      @(negedge clk);
      check(out_valid == 1'b0, "R2", "strobe after 4 edges", real'(out_valid), 0.0);

      // ---------------- vector table: R3, R4, R8 ----------------
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         configure(VEC[v][0] != 0, VEC[v][1]);
         for (int n = 0; n < SKIP + NCOR; n++) send(tone_sample(VEC[v][2], n), VEC[v][3]);
         repeat (6) @(negedge clk);
         rq = $sformatf("R%0d", VEC[v][4]);
         check(cap_n == SKIP + NCOR, "R2", $sformatf("output count, vector %0d", v),
               real'(cap_n), real'(SKIP + NCOR));
         if (VEC[v][0] != 0) begin
            wf = VEC[v][1] - VEC[v][2];
            uf = VEC[v][1] + VEC[v][2];
         end else begin
            wf = VEC[v][1] + VEC[v][2];
            uf = VEC[v][1] - VEC[v][2];
         end
         want  = tone_amp(real'(wf), SKIP, NCOR);
         other = tone_amp(real'(uf), SKIP, NCOR);
         check(want > 2000.0, rq, $sformatf("wanted tone %0d Hz, vector %0d", wf, v),
               want, 2000.0);
         check(want > 6.0 * other, rq, $sformatf("image %0d Hz x6, vector %0d", uf, v),
               6.0 * other, want);
      end

      // ---------------- R6: silence in, exact zero out ----------------
      do_reset();
      configure(1'b1, 1234);
      for (int n = 0; n < 40; n++) send(0, 3);
      repeat (6) @(negedge clk);
      nz = 0;
      for (int k = 0; k < cap_n; k++) if (cap[k] != 0) nz++;
      check(cap_n == 40, "R6", "output count for silence", real'(cap_n), 40.0);
      check(nz == 0, "R6", "non-zero outputs for silence", real'(nz), 0.0);

      // ---------------- R5: reconfiguration while busy is ignored ----------------
      do_reset();
      configure(1'b0, 2000);
      for (int n = 0; n < SKIP + NCOR; n++) begin
         if (n == 3) begin
            sb_lower = 1'b1;
            carrier_inc = inc_of(3000);
         end
         send(tone_sample(1000, n), 2);
      end
      repeat (6) @(negedge clk);
      want   = tone_amp(3000.0, SKIP, NCOR);
      other  = tone_amp(1000.0, SKIP, NCOR);
      other2 = tone_amp(2000.0, SKIP, NCOR);
      check(want > 2000.0, "R5", "original upper tone kept", want, 2000.0);
      check(want > 6.0 * other, "R5", "no switch to lower sideband", 6.0 * other, want);
      check(want > 6.0 * other2, "R5", "new carrier not applied", 6.0 * other2, want);

      // ---------------- R7: output independent of sample spacing ----------------
      do_reset();
      configure(1'b0, 2000);
      for (int n = 0; n < 48; n++) send(tone_sample(1000, n), 5);
      repeat (6) @(negedge clk);
      for (int k = 0; k < 48; k++) ref_seq[k] = cap[k];
      do_reset();
      configure(1'b0, 2000);
      for (int n = 0; n < 48; n++) send(tone_sample(1000, n), 9);
      repeat (6) @(negedge clk);
      mism = 0;
      for (int k = 0; k < 48; k++) if (cap[k] != ref_seq[k]) mism++;
      check(cap_n == 48, "R7", "output count, wide spacing", real'(cap_n), 48.0);
      check(mism == 0, "R7", "samples differing between spacings", real'(mism), 0.0);

      report();
      $finish;
   end
endmodule